// File: doc/BRIEF.md
# Direct Digital Synthesis Sine Generator

This block is a numerically controlled sine source. A wide phase register advances by a programmable step on every enabled clock. The upper bits of that register select one entry of a single-period sine table, and the registered table output forms a signed sample stream for an external converter. The output frequency is step · f_clk / 2^PHASE_W. With the default 32-bit phase and a 20 MHz clock, the frequency resolution is roughly 4.66 mHz and the range runs from DC to just under half the clock.

The step does not have to divide 2^PHASE_W. For that reason the phase register is never forced back to zero at the end of a period, and consecutive output periods can pick different table entries. A new step is taken with a load strobe. The phase carries on from where it was, so the waveform has no phase jump. A step larger than the highest legal value is clamped when it is loaded, and a sticky flag records the clamp. The sine table is computed during elaboration, so the block needs no external file.

Top module: `dds_sine_gen`

## Requirements
- R1: On each rising edge with `en` high, `phase` becomes (phase + active step) modulo 2^PHASE_W. With `en` low, `phase` holds its value.
- R2: `sample` is a two's-complement value equal to round((2^(AMP_W-1) − 1) · sin(2πk / 2^ADDR_W)). Here k is `phase[PHASE_W-1 -: ADDR_W]` as it stood just before the edge that updates `sample`, so `sample` lags `phase` by one clock. The lower phase bits play no part in addressing.
- R3: A word presented with `freq_load` high becomes the active step at that edge. It is first used by the phase update on the following edge. Loading never changes `phase`.
- R4: A loaded word greater than 2^(PHASE_W-1) − 1 (that is, with bit PHASE_W−1 set) is replaced by 2^(PHASE_W-1) − 1.
- R5: `range_err` goes high on the edge that loads an out-of-range word. After that it stays high until reset, including when later loads are legal.
- R6: `sample_valid` equals the value `en` had at the previous rising edge.
- R7: While `rst_n` is low at a rising edge, the block clears `phase`, the active step, `sample_valid` and `range_err` to zero, and sets `sample` to the phase-zero table value, which is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the phase on this clock |
| freq_word | input | PHASE_W | Requested phase step |
| freq_load | input | 1 | Capture `freq_word` as the active step |
| sample | output | AMP_W | Signed sine amplitude |
| sample_valid | output | 1 | `en` delayed by one clock |
| phase | output | PHASE_W | Current phase register |
| range_err | output | 1 | Sticky: an out-of-range step was clamped |

## Verification
The embedded properties assume that `freq_word` and `freq_load` are at known levels at every sampled edge. They also assume that `en` is a plain level with no meaning tied to the load, so a step change and the phase advance in the same cycle must behave as R3 describes. The stimulus changes inputs only at falling edges and holds them across each rising edge. It deliberately includes a load together with `en`, a load of an out-of-range word, and a reset in the middle of a run, so that every property is exercised inside these assumptions.

// File: rtl/dds_pkg.sv
// dds_pkg: shared helpers for the sine generator.
// Assumes: amplitude widths below 31 bits and table address widths below 31 bits.
package dds_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded sine value for table index idx of a 2^addr_w table, amp_w-bit signed.
    function automatic int sine_point(input int idx, input int addr_w, input int amp_w);
        real ang;
        real mag;
        real v;
        ang = TWO_PI * real'(idx) / real'(1 << addr_w);
        mag = real'((1 << (amp_w - 1)) - 1);
        v   = mag * $sin(ang);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/dds_freq_reg.sv
// dds_freq_reg: holds the active phase step.
// Clamps any loaded word above the largest legal step (half range minus one)
// and keeps a sticky flag of such clamps.
// Assumes: freq_load is a single-cycle or level strobe sampled at each edge.
module dds_freq_reg #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic               freq_load,
    output logic [PHASE_W-1:0] step_q,
    output logic               range_err
);

    localparam logic [PHASE_W-1:0] MAX_STEP = {1'b0, {(PHASE_W-1){1'b1}}};

    logic               over;
    logic [PHASE_W-1:0] step_d;

    // Detect an out-of-range request and form the clamped step.
    always_comb begin
        over   = (freq_word > MAX_STEP);
        step_d = over ? MAX_STEP : freq_word;
    end

    // Capture the step on load; accumulate the sticky range flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            range_err <= 1'b0;
        end else if (freq_load) begin
            step_q    <= step_d;
            range_err <= range_err | over;
        end
    end

    assert_step_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= MAX_STEP);

    assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_load |=> $stable(step_q));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err);

    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_load && freq_word[PHASE_W-1]) |=> range_err);

endmodule

// File: rtl/dds_phase_acc.sv
// dds_phase_acc: modulo-2^PHASE_W phase accumulator.
// Adds the active step on each enabled clock. It never rewinds at a period
// boundary, so the phase stays continuous across step changes.
// Assumes: step is already clamped by the caller.
module dds_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase_q
);

    // Advance the phase by the step with natural wrap-around.
    always_ff @(posedge clk) begin
        if (!rst_n)  phase_q <= '0;
        else if (en) phase_q <= phase_q + step;
    end

    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_q));

    assert_zero_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> $stable(phase_q));

endmodule

// File: rtl/dds_sine_rom.sv
// dds_sine_rom: one-period sine table with a registered read port.
// Entries are computed during elaboration. The read is registered every clock,
// and the valid flag is the enable delayed by one clock.
// Assumes: ADDR_W small enough for an on-chip table (default 1024 entries).
module dds_sine_rom #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    en,
    output logic signed [AMP_W-1:0] sample_q,
    output logic                    valid_q
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-1:0] table_mem [DEPTH];

    // One elaboration-time constant per table slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int VAL = dds_pkg::sine_point(i, ADDR_W, AMP_W);
        assign table_mem[i] = AMP_W'(VAL);
    end

    // Registered table read and delayed enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= $signed(table_mem[0]);
            valid_q  <= 1'b0;
        end else begin
            sample_q <= $signed(table_mem[addr]);
            valid_q  <= en;
        end
    end

    assert_amp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q <= AMP_MAX) && (sample_q >= -AMP_MAX));

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> valid_q);

    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> !valid_q);

endmodule

// File: rtl/dds_sine_gen.sv
// dds_sine_gen: direct digital synthesis sine source.
// Frequency register, phase accumulator and truncated-phase sine lookup.
// Assumes: ADDR_W <= PHASE_W; inputs synchronous to clk.
module dds_sine_gen #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PHASE_W-1:0]      freq_word,
    input  logic                    freq_load,
    output logic signed [AMP_W-1:0] sample,
    output logic                    sample_valid,
    output logic [PHASE_W-1:0]      phase,
    output logic                    range_err
);

    logic [PHASE_W-1:0] step_w;
    logic [ADDR_W-1:0]  tbl_addr;

    dds_freq_reg #(.PHASE_W(PHASE_W)) u_freq (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_word (freq_word),
        .freq_load (freq_load),
        .step_q    (step_w),
        .range_err (range_err)
    );

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .step    (step_w),
        .phase_q (phase)
    );

    // Only the top ADDR_W phase bits address the table.
    assign tbl_addr = phase[PHASE_W-1 -: ADDR_W];

    dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (tbl_addr),
        .en       (en),
        .sample_q (sample),
        .valid_q  (sample_valid)
    );

endmodule

// File: tb/dds_sine_gen_tb.sv
module dds_sine_gen_tb;

    localparam int PW = 32;
    localparam int AW = 10;
    localparam int SW = 12;
    localparam logic [PW-1:0] MAXS = 32'h7FFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [PW-1:0] freq_word = '0;
    logic freq_load = 1'b0;
    logic signed [SW-1:0] sample;
    logic sample_valid;
    logic [PW-1:0] phase;
    logic range_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dds_sine_gen #(.PHASE_W(PW), .ADDR_W(AW), .AMP_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
        .freq_load(freq_load), .sample(sample), .sample_valid(sample_valid),
        .phase(phase), .range_err(range_err)
    );

    localparam logic [PW-1:0] VW [7] = '{32'h0000_0001, 32'h0100_0000, 32'h4000_0000,
                                         MAXS, 32'h8000_0000, 32'h1234_5678, 32'h0000_0000};
    localparam int VN [7] = '{5, 3, 3, 4, 2, 7, 3};

    // Expected sine value from R2.
    function automatic int exp_sine(input logic [PW-1:0] ph);
        real v;
        v = 2047.0 * $sin(6.283185307179586 * real'(int'(ph[PW-1 -: AW])) / 1024.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [PW-1:0] mphase;
    logic [PW-1:0] mstep;
    logic [PW-1:0] prev;
    logic          merr;

    initial begin
        mphase = '0; mstep = '0; merr = 1'b0;
        repeat (2) @(negedge clk);
        // R7 reset state
        chk("R7 phase", phase, 0);
        chk("R7 sample", sample, 0);
        chk("R7 valid", sample_valid, 0);
        chk("R7 err", range_err, 0);
        rst_n = 1'b1;

        // Vector walk: R1 R2 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            freq_word = VW[i]; freq_load = 1'b1; en = 1'b0;
            @(negedge clk);
            freq_load = 1'b0; en = 1'b1;
            mstep = (VW[i] > MAXS) ? MAXS : VW[i];
            merr  = merr | (VW[i] > MAXS);
            chk("R3 load keeps phase", phase, mphase);
            prev = mphase + mstep * 32'(VN[i] - 1);
            repeat (VN[i]) @(negedge clk);
            mphase = mphase + mstep * 32'(VN[i]);
            en = 1'b0;
            chk("R1 R4 phase", phase, mphase);
            chk("R2 sample", sample, exp_sine(prev));
            chk("R6 valid", sample_valid, 1);
            chk("R5 err", range_err, merr);
        end

        // R1: phase holds with en low
        repeat (3) @(negedge clk);
        chk("R1 hold", phase, mphase);
        chk("R6 valid low", sample_valid, 0);

        // R3: load together with en; old step used first, new one next
        freq_word = 32'h0040_0000; freq_load = 1'b1; en = 1'b1;
        @(negedge clk);
        freq_load = 1'b0;
        mphase = mphase + mstep;
        chk("R3 old step first", phase, mphase);
        @(negedge clk);
        en = 1'b0;
        prev = mphase;
        mphase = mphase + 32'h0040_0000;
        chk("R3 new step next", phase, mphase);
        chk("R2 sample lag", sample, exp_sine(prev));

        // R6: valid follows en by one clock
        @(negedge clk);
        en = 1'b1;
        chk("R6 before edge", sample_valid, 0);
        @(negedge clk);
        en = 1'b0;
        mphase = mphase + 32'h0040_0000;
        chk("R6 after edge", sample_valid, 1);
        @(negedge clk);
        chk("R6 drop", sample_valid, 0);
        chk("R5 still set", range_err, 1);

        // R7: reset mid-run, then enable without load keeps phase zero
        en = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R7 phase mid", phase, 0);
        chk("R7 sample mid", sample, 0);
        chk("R7 valid mid", sample_valid, 0);
        chk("R7 err mid", range_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b0;
        chk("R7 step cleared", phase, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule